// File: doc/BRIEF.md
# Snooping Cache Coherence Fabric

This block models four private caches that share one memory over a single snooping bus. Each cache is direct-mapped and holds one data word per line. Each line carries a coherence state: Invalid, Shared, Exclusive or Modified. A build option adds a fifth state, Owned. With Owned enabled, a dirty line can be handed from one cache to another without a memory write. Each processor port issues read and write requests. The fabric serialises them on the bus, snoops every peer cache in the same cycle, updates all affected lines and returns one response.

Requests are granted round-robin, one at a time. A granted request takes three phases:
- Grant latches the request.
- Evict clears a conflicting line in the requester and writes it back if it is dirty.
- Execute looks up all caches, decides the bus command and data source, updates the states and issues the response.

The bus outputs show which command went out, whether a peer cache supplied the data, and whether memory was written. This makes the protocol decisions visible from outside.

Top module: `coh_fabric`

## Requirements
- R1: After reset, `bus_cmd` is NONE (0), `resp_valid` and `mem_wr` are 0, and every line is Invalid. The first access to any address therefore misses: a read issues RD (1) and a write issues RDX (2).
- R2: Requests are served one at a time. The arbiter is round-robin: when all four caches request together, they complete in consecutive index order, modulo 4, each exactly once. Each completion is a single-cycle, one-hot `resp_valid` pulse. This pulse comes on the third rising edge after an idle fabric sees the request.
- R3: A read miss with no other holder fills the line Exclusive. A later write to it by the same cache issues no bus command (NONE) and no memory write.
- R4: A read miss while a peer holds the line issues RD, and both copies become Shared. A later write by either holder issues UPG (3).
- R5: A write to a Shared or Owned line issues UPG and invalidates every other copy. A former holder's next read misses (RD) and returns the new value.
- R6: A write miss issues RDX. Every other copy is invalidated, and their next access misses.
- R7: With Owned enabled, a read snoop of a Modified line supplies data cache-to-cache (`bus_c2c`=1) with no memory write. The holder becomes Owned and keeps supplying later readers without writing memory.
- R8: With Owned enabled, an Owned line reaches memory only when it is evicted. The evicting request shows a WB (4) cycle with `mem_wr`=1 and `bus_addr` equal to the victim address. The written value is then what memory returns.
- R9: With Owned disabled, a read snoop of a Modified line writes it back (`mem_wr`=1, `bus_c2c`=1), and the holder drops to Shared. Evicting that clean line later issues no WB.
- R10: With Owned disabled, a write snoop (RDX) of a Modified line writes it back to memory, and the holder drops to Invalid.
- R11: Every read returns the value of the most recent write to that address, from any cache.
- R12: At no time does more than one cache hold a given address in Modified, Exclusive or Owned.
- R13: A read hit in any valid state, and a write hit in Exclusive or Modified, issue no bus command. A bus command of RD, RDX or UPG always comes with a response in the same cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | NC | Per-cache request; held until that cache's `resp_valid` pulses |
| req_write | input | NC | Per-cache request is a write |
| req_addr | input | NC*AW | Per-cache word address, cache i in bits [i*AW +: AW] |
| req_wdata | input | NC*DW | Per-cache write data, cache i in bits [i*DW +: DW] |
| resp_valid | output | NC | One-hot completion pulse |
| resp_rdata | output | DW | Read data (write data echoed for writes) |
| bus_cmd | output | 3 | Bus command of the last phase: 0 NONE, 1 RD, 2 RDX, 3 UPG, 4 WB |
| bus_addr | output | AW | Address of the bus command |
| bus_c2c | output | 1 | Read fill data came from a peer cache |
| mem_wr | output | 1 | Memory was written in the last phase |

## Verification
The bench builds two copies side by side with four caches, 4-bit addresses, four lines per cache and 8-bit data: `uut` with the Owned state enabled and `uut_mesi` with it disabled. Both copies get identical stimulus. Their different writeback and sourcing behaviour is therefore compared on the same sequence.

A directed walk takes one address through every state transition, including evictions by a conflicting tag in the same line. All four caches then request at once to exercise the arbiter. A long mixed read/write run over six addresses that share two line indices follows, with every read checked against the last written value.

// File: rtl/coh_pkg.sv
package coh_pkg;
  localparam logic [2:0] ST_I = 3'd0;
  localparam logic [2:0] ST_S = 3'd1;
  localparam logic [2:0] ST_E = 3'd2;
  localparam logic [2:0] ST_M = 3'd3;
  localparam logic [2:0] ST_O = 3'd4;

  typedef enum logic [2:0] {
    CMD_NONE = 3'd0,
    CMD_RD   = 3'd1,
    CMD_RDX  = 3'd2,
    CMD_UPG  = 3'd3,
    CMD_WB   = 3'd4
  } bus_cmd_e;

  function automatic logic is_dirty(input logic [2:0] st);
    return (st == ST_M) || (st == ST_O);
  endfunction
endpackage

// File: rtl/coh_rr_arb.sv
module coh_rr_arb #(
  parameter int N  = 4,
  parameter int CW = 2
) (
  input  logic          clk,
  input  logic          rst,
  input  logic [N-1:0]  req,
  input  logic          adv,
  output logic [CW-1:0] grant_id,
  output logic          grant_any
);
  logic [CW-1:0] ptr_q;

  always_comb begin
    grant_any = 1'b0;
    grant_id  = ptr_q;
    for (int k = 0; k < N; k++) begin
      int t;
      t = int'(ptr_q) + k;
      if (t >= N) t = t - N;
      if (!grant_any && req[t]) begin
        grant_any = 1'b1;
        grant_id  = CW'(t);
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) ptr_q <= '0;
    else if (adv && grant_any)
      ptr_q <= (int'(grant_id) == N - 1) ? '0 : grant_id + 1'b1;
  end
endmodule

// File: rtl/coh_memory.sv
module coh_memory #(
  parameter int AW = 4,
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic          we,
  input  logic [AW-1:0] waddr,
  input  logic [DW-1:0] wdata,
  input  logic [AW-1:0] raddr,
  output logic [DW-1:0] rdata
);
  localparam int DEPTH = 1 << AW;
  logic [DW-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (we) mem[waddr] <= wdata;
    rdata <= mem[raddr];
  end
endmodule

// File: rtl/coh_line_store.sv
module coh_line_store #(
  parameter int IW = 2,
  parameter int TW = 2,
  parameter int DW = 8,
  parameter int SW = 3
) (
  input  logic          clk,
  input  logic          rst,
  input  logic [IW-1:0] rd_idx,
  output logic [2:0]    rd_state,
  output logic [TW-1:0] rd_tag,
  output logic [DW-1:0] rd_data,
  input  logic          wr_en,
  input  logic [IW-1:0] wr_idx,
  input  logic [2:0]    wr_state,
  input  logic [TW-1:0] wr_tag,
  input  logic [DW-1:0] wr_data
);
  localparam int NL = 1 << IW;

  logic [SW-1:0] st_q  [NL];
  logic [TW-1:0] tag_q [NL];
  logic [DW-1:0] dat_q [NL];

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < NL; i++) st_q[i] <= '0;
    end else if (wr_en) begin
      st_q[wr_idx] <= wr_state[SW-1:0];
    end
  end

  always_ff @(posedge clk) begin
    if (wr_en) begin
      tag_q[wr_idx] <= wr_tag;
      dat_q[wr_idx] <= wr_data;
    end
  end

  always_comb begin
    rd_state = '0;
    rd_state[SW-1:0] = st_q[rd_idx];
    rd_tag  = tag_q[rd_idx];
    rd_data = dat_q[rd_idx];
  end
endmodule

// File: rtl/coh_fabric.sv
module coh_fabric
  import coh_pkg::*;
#(
  parameter int NC       = 4,
  parameter int AW       = 4,
  parameter int IW       = 2,
  parameter int DW       = 8,
  parameter bit OWNER_EN = 1'b1
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [NC-1:0]    req_valid,
  input  logic [NC-1:0]    req_write,
  input  logic [NC*AW-1:0] req_addr,
  input  logic [NC*DW-1:0] req_wdata,
  output logic [NC-1:0]    resp_valid,
  output logic [DW-1:0]    resp_rdata,
  output logic [2:0]       bus_cmd,
  output logic [AW-1:0]    bus_addr,
  output logic             bus_c2c,
  output logic             mem_wr
);
  localparam int TW = AW - IW;
  localparam int CW = (NC > 1) ? $clog2(NC) : 1;
  localparam int SW = OWNER_EN ? 3 : 2;

  typedef enum logic [1:0] {PH_IDLE, PH_EVICT, PH_EXEC} phase_e;

  phase_e        ph;
  logic [CW-1:0] cur_id;
  logic          cur_wr;
  logic [AW-1:0] cur_addr;
  logic [DW-1:0] cur_wdata;
  logic [IW-1:0] cur_idx;
  logic [TW-1:0] cur_tag;
  assign cur_idx = cur_addr[IW-1:0];
  assign cur_tag = cur_addr[AW-1:IW];

  // arbitration
  logic [CW-1:0] arb_id;
  logic          arb_any;
  coh_rr_arb #(.N(NC), .CW(CW)) u_arb (
    .clk(clk), .rst(rst), .req(req_valid & ~resp_valid),
    .adv(ph == PH_IDLE), .grant_id(arb_id), .grant_any(arb_any)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      ph        <= PH_IDLE;
      cur_id    <= '0;
      cur_wr    <= 1'b0;
      cur_addr  <= '0;
      cur_wdata <= '0;
    end else begin
      case (ph)
        PH_IDLE: if (arb_any) begin
          cur_id    <= arb_id;
          cur_wr    <= req_write[arb_id];
          cur_addr  <= req_addr[int'(arb_id)*AW +: AW];
          cur_wdata <= req_wdata[int'(arb_id)*DW +: DW];
          ph        <= PH_EVICT;
        end
        PH_EVICT: ph <= PH_EXEC;
        default:  ph <= PH_IDLE;
      endcase
    end
  end

  // per-cache line stores
  logic [2:0]    c_st   [NC];
  logic [TW-1:0] c_tag  [NC];
  logic [DW-1:0] c_dat  [NC];
  logic          c_we   [NC];
  logic [2:0]    c_wst  [NC];
  logic [TW-1:0] c_wtag [NC];
  logic [DW-1:0] c_wdat [NC];
  logic [NC*3-1:0]  st_flat;
  logic [NC*TW-1:0] tag_flat;
  logic             in_exec;
  assign in_exec = (ph == PH_EXEC);

  for (genvar g = 0; g < NC; g++) begin : g_cache
    coh_line_store #(.IW(IW), .TW(TW), .DW(DW), .SW(SW)) u_store (
      .clk(clk), .rst(rst),
      .rd_idx(cur_idx), .rd_state(c_st[g]), .rd_tag(c_tag[g]), .rd_data(c_dat[g]),
      .wr_en(c_we[g]), .wr_idx(cur_idx), .wr_state(c_wst[g]),
      .wr_tag(c_wtag[g]), .wr_data(c_wdat[g])
    );
    assign st_flat[g*3 +: 3]   = c_st[g];
    assign tag_flat[g*TW +: TW] = c_tag[g];
  end

  // shared memory
  logic          mem_we;
  logic [AW-1:0] mem_waddr;
  logic [DW-1:0] mem_wdata;
  logic [DW-1:0] mem_q;
  coh_memory #(.AW(AW), .DW(DW)) u_mem (
    .clk(clk), .we(mem_we), .waddr(mem_waddr), .wdata(mem_wdata),
    .raddr(cur_addr), .rdata(mem_q)
  );

  // snoop collection across peers
  logic [NC-1:0] peer_hit;
  logic          peer_any, dirty_any;
  logic [DW-1:0] dirty_dat;
  logic [2:0]    own_st;
  logic [TW-1:0] own_tag;
  logic [DW-1:0] own_dat;
  logic          own_hit;

  always_comb begin
    peer_any  = 1'b0;
    dirty_any = 1'b0;
    dirty_dat = '0;
    for (int j = 0; j < NC; j++) begin
      peer_hit[j] = (CW'(j) != cur_id) && (c_st[j] != ST_I) && (c_tag[j] == cur_tag);
      if (peer_hit[j]) begin
        peer_any = 1'b1;
        if (is_dirty(c_st[j])) begin
          dirty_any = 1'b1;
          dirty_dat = c_dat[j];
        end
      end
    end
    own_st  = c_st[cur_id];
    own_tag = c_tag[cur_id];
    own_dat = c_dat[cur_id];
    own_hit = (own_st != ST_I) && (own_tag == cur_tag);
  end

  // transaction decision
  bus_cmd_e      nxt_cmd;
  logic [AW-1:0] nxt_baddr;
  logic          nxt_c2c;
  logic [NC-1:0] nxt_resp;
  logic [DW-1:0] nxt_rdata;

  always_comb begin
    for (int j = 0; j < NC; j++) begin
      c_we[j]   = 1'b0;
      c_wst[j]  = c_st[j];
      c_wtag[j] = c_tag[j];
      c_wdat[j] = c_dat[j];
    end
    mem_we    = 1'b0;
    mem_waddr = cur_addr;
    mem_wdata = dirty_dat;
    nxt_cmd   = CMD_NONE;
    nxt_baddr = '0;
    nxt_c2c   = 1'b0;
    nxt_resp  = '0;
    nxt_rdata = '0;
    if (ph == PH_EVICT) begin
      if (own_st != ST_I && own_tag != cur_tag) begin
        c_we[cur_id]  = 1'b1;
        c_wst[cur_id] = ST_I;
        if (is_dirty(own_st)) begin
          mem_we    = 1'b1;
          mem_waddr = {own_tag, cur_idx};
          mem_wdata = own_dat;
          nxt_cmd   = CMD_WB;
          nxt_baddr = {own_tag, cur_idx};
        end
      end
    end else if (ph == PH_EXEC) begin
      nxt_resp[cur_id] = 1'b1;
      nxt_baddr        = cur_addr;
      if (!cur_wr && own_hit) begin
        nxt_rdata = own_dat;
      end else if (!cur_wr) begin
        nxt_cmd        = CMD_RD;
        nxt_c2c        = dirty_any;
        nxt_rdata      = dirty_any ? dirty_dat : mem_q;
        c_we[cur_id]   = 1'b1;
        c_wst[cur_id]  = peer_any ? ST_S : ST_E;
        c_wtag[cur_id] = cur_tag;
        c_wdat[cur_id] = nxt_rdata;
        for (int j = 0; j < NC; j++) begin
          if (peer_hit[j]) begin
            if (c_st[j] == ST_E) begin
              c_we[j]  = 1'b1;
              c_wst[j] = ST_S;
            end else if (c_st[j] == ST_M) begin
              c_we[j]  = 1'b1;
              c_wst[j] = OWNER_EN ? ST_O : ST_S;
              if (!OWNER_EN) mem_we = 1'b1;
            end
          end
        end
      end else begin
        nxt_rdata = cur_wdata;
        if (own_hit && (own_st == ST_E || own_st == ST_M)) nxt_cmd = CMD_NONE;
        else if (own_hit)                                   nxt_cmd = CMD_UPG;
        else                                                nxt_cmd = CMD_RDX;
        c_we[cur_id]   = 1'b1;
        c_wst[cur_id]  = ST_M;
        c_wtag[cur_id] = cur_tag;
        c_wdat[cur_id] = cur_wdata;
        for (int j = 0; j < NC; j++) begin
          if (peer_hit[j]) begin
            c_we[j]  = 1'b1;
            c_wst[j] = ST_I;
            if (!OWNER_EN && c_st[j] == ST_M) mem_we = 1'b1;
          end
        end
      end
    end
  end

  // registered outputs
  always_ff @(posedge clk) begin
    if (rst) begin
      bus_cmd    <= CMD_NONE;
      bus_addr   <= '0;
      bus_c2c    <= 1'b0;
      mem_wr     <= 1'b0;
      resp_valid <= '0;
      resp_rdata <= '0;
    end else begin
      bus_cmd    <= nxt_cmd;
      bus_addr   <= nxt_baddr;
      bus_c2c    <= nxt_c2c;
      mem_wr     <= mem_we;
      resp_valid <= nxt_resp;
      resp_rdata <= nxt_rdata;
    end
  end
endmodule

// File: rtl/coh_fabric_chk.sv
module coh_fabric_chk
  import coh_pkg::*;
#(
  parameter int NC       = 4,
  parameter int TW       = 2,
  parameter bit OWNER_EN = 1'b1
) (
  input logic             clk,
  input logic             rst,
  input logic [NC-1:0]    resp_valid,
  input logic [2:0]       bus_cmd,
  input logic             bus_c2c,
  input logic             mem_wr,
  input logic             in_exec,
  input logic [NC*3-1:0]  st_flat,
  input logic [NC*TW-1:0] tag_flat,
  input logic [TW-1:0]    cur_tag
);
  int excl_cnt;
  always_comb begin
    excl_cnt = 0;
    for (int j = 0; j < NC; j++) begin
      if (tag_flat[j*TW +: TW] == cur_tag &&
          (st_flat[j*3 +: 3] == ST_E || st_flat[j*3 +: 3] == ST_M || st_flat[j*3 +: 3] == ST_O))
        excl_cnt++;
    end
  end

  p_single_owner_r12: assert property (@(posedge clk) disable iff (rst)
    in_exec |-> excl_cnt <= 1);

  p_resp_onehot_r2: assert property (@(posedge clk) disable iff (rst)
    $onehot0(resp_valid));

  p_resp_pulse_r2: assert property (@(posedge clk) disable iff (rst)
    (|resp_valid) |=> (resp_valid == '0));

  p_upg_quiet_r5: assert property (@(posedge clk) disable iff (rst)
    (bus_cmd == CMD_UPG) |-> (!mem_wr && !bus_c2c));

  p_owner_no_flush_r7: assert property (@(posedge clk) disable iff (rst)
    (OWNER_EN && bus_cmd == CMD_RD) |-> !mem_wr);

  p_flush_on_snoop_r9: assert property (@(posedge clk) disable iff (rst)
    (!OWNER_EN && bus_cmd == CMD_RD && bus_c2c) |-> mem_wr);

  p_wb_writes_r8: assert property (@(posedge clk) disable iff (rst)
    (bus_cmd == CMD_WB) |-> (mem_wr && resp_valid == '0));

  p_cmd_has_resp_r13: assert property (@(posedge clk) disable iff (rst)
    (bus_cmd == CMD_RD || bus_cmd == CMD_RDX || bus_cmd == CMD_UPG) |-> (|resp_valid));
endmodule

bind coh_fabric coh_fabric_chk #(.NC(NC), .TW(TW), .OWNER_EN(OWNER_EN)) u_chk (
  .clk(clk), .rst(rst), .resp_valid(resp_valid), .bus_cmd(bus_cmd),
  .bus_c2c(bus_c2c), .mem_wr(mem_wr), .in_exec(in_exec),
  .st_flat(st_flat), .tag_flat(tag_flat), .cur_tag(cur_tag)
);

// File: tb/coh_fabric_test.sv
`timescale 1ns/1ps
module coh_fabric_test;
  localparam int NC = 4;
  localparam int AW = 4;
  localparam int DW = 8;

  logic clk = 1'b0;
  always #4 clk = ~clk;

  logic             rst;
  logic [NC-1:0]    req_valid;
  logic [NC-1:0]    req_write;
  logic [NC*AW-1:0] req_addr;
  logic [NC*DW-1:0] req_wdata;

  logic [NC-1:0] rv    [2];
  logic [DW-1:0] rdata [2];
  logic [2:0]    bcmd  [2];
  logic [AW-1:0] baddr [2];
  logic          c2c   [2];
  logic          mw    [2];

  coh_fabric #(.NC(NC), .AW(AW), .IW(2), .DW(DW), .OWNER_EN(1'b1)) uut (
    .clk(clk), .rst(rst), .req_valid(req_valid), .req_write(req_write),
    .req_addr(req_addr), .req_wdata(req_wdata), .resp_valid(rv[0]),
    .resp_rdata(rdata[0]), .bus_cmd(bcmd[0]), .bus_addr(baddr[0]),
    .bus_c2c(c2c[0]), .mem_wr(mw[0]));

  coh_fabric #(.NC(NC), .AW(AW), .IW(2), .DW(DW), .OWNER_EN(1'b0)) uut_mesi (
    .clk(clk), .rst(rst), .req_valid(req_valid), .req_write(req_write),
    .req_addr(req_addr), .req_wdata(req_wdata), .resp_valid(rv[1]),
    .resp_rdata(rdata[1]), .bus_cmd(bcmd[1]), .bus_addr(baddr[1]),
    .bus_c2c(c2c[1]), .mem_wr(mw[1]));

  int checks = 0;
  int errors = 0;
  int cyc = 0;

  int r_cmd[2], r_c2c[2], r_mw[2], r_wb[2], r_wba[2], r_data[2], r_got[2];
  int r_lat;
  int golden[16];

  task automatic summary();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc > 150000) begin
      checks++;
      errors++;
      $display("FAIL watchdog: got %0d cycles expected fewer than 150000", cyc);
      summary();
      $finish;
    end
  end

  task automatic chk(input string rq, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: got %0h expected %0h", rq, act, exp);
    end
  endtask

  // expectation for owner-enabled copy (k=0) and owner-disabled copy (k=1)
  task automatic chk2(input string rq, input int a0, input int e0, input int a1, input int e1);
    chk({rq, " [owner]"}, a0, e0);
    chk({rq, " [mesi]"}, a1, e1);
  endtask

  task automatic op(input int c, input bit w, input int a, input int d);
    @(negedge clk);
    req_valid[c] = 1'b1;
    req_write[c] = w;
    req_addr[c*AW +: AW]  = AW'(a);
    req_wdata[c*DW +: DW] = DW'(d);
    for (int k = 0; k < 2; k++) begin r_wb[k] = 0; r_wba[k] = 0; end
    r_lat = 0;
    do begin
      @(negedge clk);
      r_lat++;
      for (int k = 0; k < 2; k++)
        if (bcmd[k] == 3'd4) begin r_wb[k] = 1; r_wba[k] = int'(baddr[k]); end
    end while (!rv[0][c] && r_lat < 20);
    for (int k = 0; k < 2; k++) begin
      r_cmd[k]  = int'(bcmd[k]);
      r_c2c[k]  = int'(c2c[k]);
      r_mw[k]   = int'(mw[k]);
      r_data[k] = int'(rdata[k]);
      r_got[k]  = int'(rv[k][c]);
    end
    req_valid[c] = 1'b0;
    chk("R2 latency", r_lat, 3);
    chk2("R2 response", r_got[0], 1, r_got[1], 1);
  endtask

  initial begin
    rst = 1'b1;
    req_valid = '0; req_write = '0; req_addr = '0; req_wdata = '0;
    repeat (4) @(posedge clk);
    @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    chk2("R1 reset bus_cmd", int'(bcmd[0]), 0, int'(bcmd[1]), 0);
    chk2("R1 reset resp", int'(rv[0]), 0, int'(rv[1]), 0);
    chk2("R1 reset mem_wr", int'(mw[0]), 0, int'(mw[1]), 0);

    // address 1 walked through the states
    op(0, 1, 1, 8'h11);
    chk2("R1 first write RDX", r_cmd[0], 2, r_cmd[1], 2);
    op(0, 1, 1, 8'h12);
    chk2("R13 write hit M silent", r_cmd[0], 0, r_cmd[1], 0);
    op(1, 0, 1, 0);
    chk2("R7/R9 read snoop M cmd", r_cmd[0], 1, r_cmd[1], 1);
    chk2("R7/R9 c2c", r_c2c[0], 1, r_c2c[1], 1);
    chk2("R7/R9 mem write", r_mw[0], 0, r_mw[1], 1);
    chk2("R11 read data", r_data[0], 8'h12, r_data[1], 8'h12);
    op(2, 0, 1, 0);
    chk2("R7/R9 second reader source", r_c2c[0], 1, r_c2c[1], 0);
    chk2("R7 owner keeps memory", r_mw[0], 0, r_mw[1], 0);
    chk2("R9 writeback data", r_data[0], 8'h12, r_data[1], 8'h12);
    op(1, 1, 1, 8'h13);
    chk2("R5 write shared UPG", r_cmd[0], 3, r_cmd[1], 3);
    op(2, 0, 1, 0);
    chk2("R5 invalidated reader misses", r_cmd[0], 1, r_cmd[1], 1);
    chk2("R5 new value", r_data[0], 8'h13, r_data[1], 8'h13);
    chk2("R9 flush on read snoop", r_mw[0], 0, r_mw[1], 1);
    op(3, 1, 1, 8'h14);
    chk2("R6 write miss RDX", r_cmd[0], 2, r_cmd[1], 2);
    chk2("R6 clean peers no mem write", r_mw[0], 0, r_mw[1], 0);
    op(0, 1, 1, 8'h15);
    chk2("R6 RDX again", r_cmd[0], 2, r_cmd[1], 2);
    chk2("R10 write snoop M flush", r_mw[0], 0, r_mw[1], 1);
    op(3, 0, 1, 0);
    chk2("R6 invalidated writer misses", r_cmd[0], 1, r_cmd[1], 1);
    chk2("R11 read after RDX", r_data[0], 8'h15, r_data[1], 8'h15);
    op(0, 0, 5, 0);
    chk2("R8/R9 eviction WB", r_wb[0], 1, r_wb[1], 0);
    chk("R8 WB address", r_wba[0], 1);
    chk2("R1 fill from memory", r_c2c[0], 0, r_c2c[1], 0);
    op(2, 0, 1, 0);
    chk2("R8 memory holds owner data", r_data[0], 8'h15, r_data[1], 8'h15);
    chk2("R8 source memory", r_c2c[0], 0, r_c2c[1], 0);

    // exclusive fill on address 2
    op(1, 0, 2, 0);
    chk2("R3 lone read miss", r_cmd[0], 1, r_cmd[1], 1);
    op(1, 1, 2, 8'h21);
    chk2("R3 write E silent", r_cmd[0], 0, r_cmd[1], 0);
    chk2("R3 no mem write", r_mw[0], 0, r_mw[1], 0);
    op(1, 0, 2, 0);
    chk2("R13 read hit silent", r_cmd[0], 0, r_cmd[1], 0);
    chk2("R13 read hit data", r_data[0], 8'h21, r_data[1], 8'h21);

    // shared pair on address 5
    op(2, 0, 5, 0);
    chk2("R4 read with peer E", r_cmd[0], 1, r_cmd[1], 1);
    chk2("R4 no eviction WB for clean", r_wb[0], 0, r_wb[1], 0);
    op(0, 1, 5, 8'h33);
    chk2("R4 write after share UPG", r_cmd[0], 3, r_cmd[1], 3);
    op(2, 0, 5, 0);
    chk2("R5 reread after UPG", r_data[0], 8'h33, r_data[1], 8'h33);

    // round-robin: all four caches read address 2 together
    begin
      int order[4];
      int n = 0;
      int guard = 0;
      @(negedge clk);
      for (int i = 0; i < NC; i++) begin
        req_valid[i] = 1'b1; req_write[i] = 1'b0; req_addr[i*AW +: AW] = 4'd2;
      end
      while (n < 4 && guard < 80) begin
        @(negedge clk);
        guard++;
        chk("R2 copies agree", int'(rv[1]), int'(rv[0]));
        for (int i = 0; i < NC; i++) begin
          if (rv[0][i]) begin
            order[n] = i;
            n++;
            req_valid[i] = 1'b0;
            chk2("R11 concurrent read", int'(rdata[0]), 8'h21, int'(rdata[1]), 8'h21);
          end
        end
      end
      chk("R2 all served", n, 4);
      for (int k = 1; k < 4; k++) chk("R2 rotation order", order[k], (order[k-1] + 1) % 4);
    end

    // mixed traffic over six addresses sharing two line indices
    begin
      int addrs[6] = '{0, 1, 4, 5, 8, 9};
      int seed = 7;
      void'($urandom(seed));
      for (int i = 0; i < 6; i++) begin
        int d = int'($urandom % 256);
        op(int'($urandom % 4), 1, addrs[i], d);
        golden[addrs[i]] = d;
      end
      for (int it = 0; it < 400; it++) begin
        int c = int'($urandom % 4);
        int a = addrs[$urandom % 6];
        if ($urandom % 2 == 0) begin
          int d = int'($urandom % 256);
          op(c, 1, a, d);
          golden[a] = d;
        end else begin
          op(c, 0, a, 0);
          chk2("R11 random read", r_data[0], golden[a], r_data[1], golden[a]);
        end
      end
    end

    repeat (4) @(negedge clk);
    summary();
    $finish;
  end
endmodule